// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital half of a power supervisor. Analog comparators outside it supply four level flags: the primary rail is above its trip point, a second monitored rail is above its own trip point, the primary rail is above the battery plus a margin, and the primary rail is below the battery minus a margin. The block also receives an active-low push-button reset. From these it drives a system reset in both polarities, an early low-supply warning, an undelayed failure flag for the second rail, and a select signal that hands the output rail to the battery.

Reset is held for a fixed stretch after every cause has gone away. The configuration bit `hold_long_i` chooses the short or the long stretch. It is treated as quasi-static. All durations are counted in prescaler ticks, so a slow real-time stretch becomes a short simulated one. Every asynchronous flag first passes through a two-flop synchronizer.

Top module: `supply_supervisor`

## Requirements
- R1: While the synchronized primary flag is low, `sys_rst_o` is 1 and `sys_rst_n_o` is 0. The two outputs are always complements.
- R2: With `hold_long_i` = 0, reset is released HOLD_SHORT ticks (±1 tick) after the last cause ends.
- R3: With `hold_long_i` = 1, the stretch is HOLD_LONG ticks (±1 tick).
- R4: While `rst_n` is low, `sys_rst_o` is 1 and `lowline_n_o`, `sec_fail_n_o` and `batt_on_o` are 0. After `rst_n` rises, reset is released only after the primary flag has been high for the hold stretch.
- R5: `mrst_n_i` low asserts reset only once it has been stable for DEB_TICKS ticks. A low pulse shorter than that leaves reset at 0.
- R6: After the push-button is released and debounced, reset stays asserted for the selected hold stretch.
- R7: `lowline_n_o` equals the primary flag two clocks after the pin, with no stretch. On a power loss it falls one clock before `sys_rst_o` rises.
- R8: `sec_fail_n_o` equals the second-rail flag two clocks after the pin, in both directions, with no stretch.
- R9: With the primary flag high, `batt_on_o` is 0. With it low, the battery is selected when the below-margin flag is 1, the primary is selected when the above-margin flag is 1, and the selection is kept when neither flag is 1.
- R10: `batt_on_o` is 1 exactly while the battery is selected. It follows a selection-changing flag three clocks after the pin.
- R11: A new cause that appears during a hold stretch restarts the stretch in full from the moment that cause ends.
- R12: A change on any flag pin has no effect on the outputs one clock later. It appears after the second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low logic reset (power-on) |
| prim_ok_i | input | 1 | Primary rail above trip (async) |
| sec_ok_i | input | 1 | Second rail above trip (async) |
| batt_above_i | input | 1 | Primary above battery plus margin (async) |
| batt_below_i | input | 1 | Primary below battery minus margin (async) |
| mrst_n_i | input | 1 | Push-button reset, active low (async, bouncy) |
| hold_long_i | input | 1 | 0: short hold stretch, 1: long hold stretch |
| sys_rst_o | output | 1 | System reset, active high |
| sys_rst_n_o | output | 1 | System reset, active low |
| lowline_n_o | output | 1 | Early low-primary warning, active low |
| sec_fail_n_o | output | 1 | Second-rail failure, active low |
| batt_on_o | output | 1 | Output rail taken from battery |

## Verification
The assertions assume that the two battery-margin flags are never 1 together, as the comparator hysteresis guarantees. They also assume that `hold_long_i` changes only while no hold stretch is running. The release check rests on a counter of quiet cycles, so it assumes the stretch length does not change partway through. The stimulus drives the margin flags exclusively and changes the configuration bit only while reset is released. It changes pins half a clock away from the active edge, which keeps every synchronizer delay exact.

// File: rtl/supsv_pkg.sv
`timescale 1ns/1ps
package supsv_pkg;

  // indices into the synchronized flag vector
  localparam int unsigned IX_PRIM  = 0;
  localparam int unsigned IX_SEC   = 1;
  localparam int unsigned IX_ABOVE = 2;
  localparam int unsigned IX_BELOW = 3;
  localparam int unsigned IX_MR    = 4;
  localparam int unsigned N_FLAGS  = 5;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // battery-select decision: primary wins above trip, otherwise hysteresis
  function automatic logic next_batt(input logic prim_ok, input logic below,
                                     input logic above, input logic cur);
    logic nxt;
    if (prim_ok)     nxt = 1'b0;
    else if (below)  nxt = 1'b1;
    else if (above)  nxt = 1'b0;
    else             nxt = cur;
    return nxt;
  endfunction

  // the cause for reset: primary below trip or accepted push-button
  function automatic logic reset_cause(input logic prim_ok, input logic mr_n_deb);
    return !prim_ok || !mr_n_deb;
  endfunction

endpackage

// File: rtl/supsv_sync.sv
`timescale 1ns/1ps
module supsv_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic ff1, ff2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ff1 <= RST_VAL[b];
        ff2 <= RST_VAL[b];
      end else begin
        ff1 <= d_i[b];
        ff2 <= ff1;
      end
    end
    assign q_o[b] = ff2;
  end
endmodule

// File: rtl/supsv_tick.sv
`timescale 1ns/1ps
module supsv_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/supsv_debounce.sv
`timescale 1ns/1ps
module supsv_debounce #(
  parameter int unsigned DEB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  output logic deb_o
);
  localparam int unsigned CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          deb_q;

  assign deb_o = deb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      deb_q <= 1'b1;
    end else if (raw_i == deb_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        deb_q <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/supsv_hold.sv
`timescale 1ns/1ps
module supsv_hold
  import supsv_pkg::*;
#(
  parameter int unsigned HOLD_SHORT = 15,
  parameter int unsigned HOLD_LONG  = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cause_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int unsigned HMAX = max_u(HOLD_SHORT, HOLD_LONG);
  localparam int unsigned CW   = $clog2(HMAX + 1);
  localparam logic [CW-1:0] LD_S = CW'(HOLD_SHORT);
  localparam logic [CW-1:0] LD_L = CW'(HOLD_LONG);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  assign load_val = long_i ? LD_L : LD_S;
  assign busy_o   = (cnt_q != '0);

  // any cause reloads the full stretch, so a new cause restarts it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (cause_i)          cnt_q <= load_val;
    else if (tick_i && busy_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/supply_supervisor.sv
`timescale 1ns/1ps
module supply_supervisor
  import supsv_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 4,
  parameter int unsigned HOLD_SHORT = 15,
  parameter int unsigned HOLD_LONG  = 80,
  parameter int unsigned DEB_TICKS  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prim_ok_i,
  input  logic sec_ok_i,
  input  logic batt_above_i,
  input  logic batt_below_i,
  input  logic mrst_n_i,
  input  logic hold_long_i,
  output logic sys_rst_o,
  output logic sys_rst_n_o,
  output logic lowline_n_o,
  output logic sec_fail_n_o,
  output logic batt_on_o
);
  localparam logic [N_FLAGS-1:0] SYNC_RST = N_FLAGS'(1) << IX_MR;

  logic [N_FLAGS-1:0] raw_w, sync_w;
  logic prim_s, sec_s, above_s, below_s, mr_s;
  logic tick_w, mr_deb_w, cause_w, hold_busy_w;
  logic rst_q, batt_q;

  assign raw_w[IX_PRIM]  = prim_ok_i;
  assign raw_w[IX_SEC]   = sec_ok_i;
  assign raw_w[IX_ABOVE] = batt_above_i;
  assign raw_w[IX_BELOW] = batt_below_i;
  assign raw_w[IX_MR]    = mrst_n_i;

  supsv_sync #(.W(N_FLAGS), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(sync_w)
  );

  assign prim_s  = sync_w[IX_PRIM];
  assign sec_s   = sync_w[IX_SEC];
  assign above_s = sync_w[IX_ABOVE];
  assign below_s = sync_w[IX_BELOW];
  assign mr_s    = sync_w[IX_MR];

  supsv_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
  );

  supsv_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .raw_i(mr_s), .deb_o(mr_deb_w)
  );

  assign cause_w = reset_cause(prim_s, mr_deb_w);

  supsv_hold #(.HOLD_SHORT(HOLD_SHORT), .HOLD_LONG(HOLD_LONG)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .cause_i(cause_w),
    .long_i(hold_long_i), .busy_o(hold_busy_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      batt_q <= 1'b0;
    end else begin
      rst_q  <= cause_w || hold_busy_w;
      batt_q <= next_batt(prim_s, below_s, above_s, batt_q);
    end
  end

  assign sys_rst_o    = rst_q;
  assign sys_rst_n_o  = !rst_q;
  assign lowline_n_o  = prim_s;
  assign sec_fail_n_o = sec_s;
  assign batt_on_o    = batt_q;
endmodule

// File: rtl/supsv_chk.sv
`timescale 1ns/1ps
module supsv_chk #(
  parameter int unsigned TICK_DIV   = 4,
  parameter int unsigned HOLD_SHORT = 15
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic mr_deb,
  input logic cause,
  input logic below_s,
  input logic above_s,
  input logic sys_rst,
  input logic sys_rst_n,
  input logic lowline_n,
  input logic batt_on
);
  int unsigned quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     quiet_q <= 0;
    else if (cause) quiet_q <= 0;
    else if (quiet_q < 32'hFFFF_0000) quiet_q <= quiet_q + 1;
  end

  p_low_prim_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lowline_n |=> sys_rst);
  p_pol_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst != sys_rst_n);
  p_release_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> quiet_q >= (HOLD_SHORT - 1) * TICK_DIV);
  p_button_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_deb |=> sys_rst);
  p_deb_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mr_deb) |-> $past(tick));
  p_rise_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(cause));
  p_prim_selects_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lowline_n |=> !batt_on);
  p_keep_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowline_n && !below_s && !above_s) |=> $stable(batt_on));
  p_enter_batt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowline_n && below_s) |=> batt_on);
endmodule

bind supply_supervisor supsv_chk #(.TICK_DIV(TICK_DIV), .HOLD_SHORT(HOLD_SHORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .mr_deb(mr_deb_w), .cause(cause_w),
  .below_s(below_s), .above_s(above_s), .sys_rst(sys_rst_o),
  .sys_rst_n(sys_rst_n_o), .lowline_n(lowline_n_o), .batt_on(batt_on_o)
);

// File: tb/supply_supervisor_tb.sv
`timescale 1ns/1ps
module supply_supervisor_tb;
  localparam int DIV = 4, HS = 15, HL = 80, DEB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prim = 1'b0, sec = 1'b0, above = 1'b0, below = 1'b0, mr_n = 1'b1, hl = 1'b0;
  logic rst, rst_n_o, ll_n, sf_n, bo;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.TICK_DIV(DIV), .HOLD_SHORT(HS), .HOLD_LONG(HL), .DEB_TICKS(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .prim_ok_i(prim), .sec_ok_i(sec),
    .batt_above_i(above), .batt_below_i(below), .mrst_n_i(mr_n),
    .hold_long_i(hl), .sys_rst_o(rst), .sys_rst_n_o(rst_n_o),
    .lowline_n_o(ll_n), .sec_fail_n_o(sf_n), .batt_on_o(bo)
  );

  // scoreboard: fields {rst, lowline_n, sec_fail_n, batt_on}
  typedef struct { string req; logic [3:0] val; logic [3:0] mask; } exp_t;
  exp_t sb_q[$];

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [3:0] act;
      e = sb_q.pop_front();
      act = {rst, ll_n, sf_n, bo};
      checks++;
      if (((act ^ e.val) & e.mask) != 0 || rst_n_o !== !rst) begin
        errors++;
        $display("FAIL %s: actual {rst,ll_n,sf_n,bo}=%b rst_n=%b expected %b mask %b",
                 e.req, act, rst_n_o, e.val, e.mask);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input logic [3:0] v, input logic [3:0] m);
    exp_t e;
    e.req = req; e.val = v; e.mask = m;
    sb_q.push_back(e);
    step(1);
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_release(output int n);
    n = 0;
    while (rst === 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n, hi_seen;
    step(3);
    // R4: reset state
    expect_out("R4 reset state", 4'b1000, 4'b1111);
    prim = 1; sec = 1; above = 1; rst_n = 1;
    step(10);
    expect_out("R4 held after power-up", 4'b1110, 4'b1111);
    wait_release(n);
    check_range("R4 power-up stretch", n + 11, (HS-1)*DIV, HS*DIV + DIV + 4);

    // R12 / R8: second rail, exact two-clock latency both ways
    sec = 0;
    expect_out("R12 no change after one clock", 4'b0010, 4'b0010);
    expect_out("R8 fail after two clocks", 4'b0000, 4'b1010);
    sec = 1;
    expect_out("R12 still failing one clock", 4'b0000, 4'b0010);
    expect_out("R8 recovery undelayed", 4'b0010, 4'b1010);

    // R7 / R1: lowline precedes reset
    prim = 0;
    expect_out("R12 lowline unchanged", 4'b0100, 4'b1100);
    expect_out("R7 lowline falls first", 4'b0000, 4'b1100);
    expect_out("R1 reset follows", 4'b1000, 4'b1100);

    // R9 / R10: battery hysteresis (primary low)
    above = 0; step(4);
    expect_out("R9 keep primary selection", 4'b0000, 4'b0001);
    below = 1; step(2);
    expect_out("R10 battery on after three clocks", 4'b0001, 4'b0001);
    below = 0; step(4);
    expect_out("R9 battery kept without flags", 4'b0001, 4'b0001);
    above = 1; step(4);
    expect_out("R9 back to primary", 4'b0000, 4'b0001);
    above = 0; below = 1; step(4);
    expect_out("R10 battery again", 4'b0001, 4'b0001);
    prim = 1; step(4);
    expect_out("R9 primary above trip wins", 4'b1100, 4'b1101);
    below = 0; above = 1;
    wait_release(n);
    check_range("R2 short stretch", n + 5, (HS-1)*DIV, HS*DIV + DIV + 4);

    // R11: restart during stretch
    prim = 0; step(10);
    prim = 1; step(30);
    expect_out("R11 still in stretch", 4'b1100, 4'b1100);
    prim = 0; step(4);
    prim = 1;
    wait_release(n);
    check_range("R11 stretch restarted", n, (HS-1)*DIV, HS*DIV + DIV + 4);

    // R5: short button glitch ignored
    step(5);
    mr_n = 0; step(6); mr_n = 1;
    hi_seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rst) hi_seen++;
    end
    #1;
    check_range("R5 glitch ignored", hi_seen, 0, 0);

    // R5 / R6: accepted press and release stretch
    mr_n = 0; step(40);
    expect_out("R5 press accepted", 4'b1100, 4'b1100);
    mr_n = 1;
    wait_release(n);
    check_range("R6 release stretch", n, (HS-1)*DIV, (HS+DEB+1)*DIV + 8);

    // R3: long stretch
    hl = 1; step(5);
    prim = 0; step(10);
    prim = 1;
    wait_release(n);
    check_range("R3 long stretch", n, (HL-1)*DIV, HL*DIV + DIV + 4);
    expect_out("R3 released state", 4'b0110, 4'b1111);

    step(2);
    done = 1;
    summary();
    $finish;
  end
endmodule